// File: doc/BRIEF.md
# SPI Register-Access Frame Slave

This block is an SPI target that serves an 8-bit register file through frames of fixed length. Each frame opens with a header byte carrying a direction bit and a 7-bit register address, followed by a data byte. In the long framing a third byte follows, carrying a 5-bit check code. While the host shifts its frame in, the block shifts a response out. The response's first byte is the channel input-state vector. Its second byte is either the wire-break vector or the addressed register's contents, depending on the direction bit.

SPI mode 0 is used, most significant bit first. The SPI pins are oversampled in the system clock domain, so the serial clock must stay well below the system clock. The length of each frame is chosen by a mode input, which the block captures when chip-select falls. A write takes effect only when chip-select rises after a frame of exactly the expected length whose check code, if present, is correct. A level fault output reports any enabled, active bit of the first fault register.

Top module: `spi_frame_regs`

## Requirements
- R1: In the header byte, bit 7 selects the direction (1 = write, 0 = read) and bits [6:0] select the address. A write frame stores its second byte in the addressed register. Writable registers are configuration at 0x18, channel enable at 0x1A, fault1 at 0x04, fault2 at 0x1C, fault2-enable at 0x1E and fault1-enable at 0x24.
- R2: The first response byte is the input-state vector as captured on the falling edge of cs_n. Later changes during the frame do not alter it.
- R3: On a write frame, the second response byte is the wire-break vector as captured on the falling edge of cs_n.
- R4: On a read frame, the second response byte is the addressed register, and the host's second byte has no effect. Address 0x00 returns the live wire-break vector and 0x02 returns the live input state. The no-operation address 0x26 and every unmapped address return 0x00.
- R5: With frame_mode = 0, a frame is 24 bits long. With frame_mode = 1, a frame is 16 bits long and carries no check code. The mode is sampled when cs_n falls.
- R6: The check code of a long frame is the 5-bit remainder of {the frame's first 19 bits, 5'b00111} divided by 6'b110101, and it sits in bits [4:0] of the third byte. The third response byte is {3'b000, code of (response byte 0, response byte 1, 3'b000)}.
- R7: A long frame whose received check code does not match changes no register and sets fault1 bit 7.
- R8: A frame that ends with any bit count other than its mode's length changes no register.
- R9: Fault1 bit 6 is 1 after reset. Fault1 bits 6 and 7 are cleared by writing 0 to them, and writing 1 leaves them as they are. Fault1 bits [4:0] take the written value.
- R10: Fault1 bit 5 is 1 exactly when any fault2 bit is 1. Fault2 and fault2-enable store bits [5:0], and their bits [7:6] read 0.
- R11: fault_o is 1 exactly while some bit of fault1 and the same bit of fault1-enable are both 1.
- R12: After reset the values are configuration 0x00, channel enable 0xFF, fault1 0x40, fault1-enable 0x00, fault2 0x00 and fault2-enable 0x00. Writes to 0x00, 0x02, 0x26 or unmapped addresses have no effect.
- R13: miso is 0 while cs_n is high, and bits past the frame's last byte are shifted out as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| frame_mode | input | 1 | 0: 3-byte frames with check code, 1: 2-byte frames |
| in_state | input | 8 | Live channel input-state vector |
| wb_state | input | 8 | Live wire-break vector |
| cfg_q | output | 8 | Configuration register |
| chan_en_q | output | 8 | Channel enable register |
| fault1_q | output | 8 | Fault1 register, including the derived bit 5 |
| fault1_en_q | output | 8 | Fault1-enable register |
| fault2_q | output | 8 | Fault2 register |
| fault2_en_q | output | 8 | Fault2-enable register |
| fault_o | output | 1 | Level fault indication |

## Verification
The pins pass through two synchronizer stages and one edge-detect stage. The header-byte load therefore lands about three clock cycles after cs_n falls, and each miso shift lands about three cycles after an sclk fall. With six system cycles per sclk half period, the monitor samples miso on each sclk rise, well after the bit settled. The register ports and fault_o change four cycles after cs_n rises, and the bench waits twelve cycles after every frame before it compares them with its own register model. Response bytes are compared as they complete, against expectations that the driver queued before the frame started.

// File: rtl/spi_frame_regs_pkg.sv
package spi_frame_regs_pkg;

  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 7;
  localparam int CHK_W       = 5;
  localparam int FRAME_BYTES = 3;
  localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
  localparam int CHK_DATA_W  = FRAME_W - CHK_W;

  localparam logic [CHK_W:0]   CHK_POLY = 6'h35;
  localparam logic [CHK_W-1:0] CHK_SEED = 5'h07;

  // register addresses; the host decodes these, so they are fixed
  localparam logic [ADDR_W-1:0] A_WIRE   = 7'h00;
  localparam logic [ADDR_W-1:0] A_INPUT  = 7'h02;
  localparam logic [ADDR_W-1:0] A_FLT1   = 7'h04;
  localparam logic [ADDR_W-1:0] A_CONFIG = 7'h18;
  localparam logic [ADDR_W-1:0] A_CHEN   = 7'h1A;
  localparam logic [ADDR_W-1:0] A_FLT2   = 7'h1C;
  localparam logic [ADDR_W-1:0] A_FLT2EN = 7'h1E;
  localparam logic [ADDR_W-1:0] A_FLT1EN = 7'h24;
  localparam logic [ADDR_W-1:0] A_NOP    = 7'h26;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } wr_cmd_t;

  // bit-serial polynomial remainder of {payload, seed}
  function automatic logic [CHK_W-1:0] chk5(input logic [CHK_DATA_W-1:0] payload);
    logic [FRAME_W-1:0] w;
    logic [CHK_W:0]     r;
    w = {payload, CHK_SEED};
    r = '0;
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      r = {r[CHK_W-1:0], w[i]};
      if (r[CHK_W]) r = r ^ CHK_POLY;
    end
    return r[CHK_W-1:0];
  endfunction

endpackage

// File: rtl/spi_frame_sync.sv
module spi_frame_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q_o = st[STAGES-1];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_frame_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              mode_i,
  input  logic [BYTE_W-1:0] in_state_i,
  input  logic [BYTE_W-1:0] wb_state_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              miso_o,
  output logic              cmd_valid_o,
  output wr_cmd_t           cmd_o,
  output logic              chk_err_o
);

  localparam int CNT_W = $clog2(FRAME_W + 1) + 1;
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(FRAME_W - BYTE_W);
  localparam logic [CNT_W-1:0] B1_AT     = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] B2_AT     = CNT_W'(2 * BYTE_W);

  logic              sclk_d, cs_d, in_frame, short_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [FRAME_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr, lat_in, lat_wb, rsp1;

  logic sclk_rise, sclk_fall, cs_fall, cs_rise;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = ~cs_n_s & cs_d;
  assign cs_rise   = cs_n_s & ~cs_d;

  // header byte sits in the low byte once 8 bits are in
  assign rd_addr_o = rx_sr[ADDR_W-1:0];

  logic [BYTE_W-1:0] byte1;
  assign byte1 = rx_sr[BYTE_W-1] ? lat_wb : rd_data_i;

  logic [CHK_W-1:0] rsp_chk;
  assign rsp_chk = chk5({lat_in, rsp1, {(BYTE_W-CHK_W){1'b0}}});

  assign miso_o = in_frame & tx_sr[BYTE_W-1];

  // frame decode at chip-select release
  logic [BYTE_W-1:0] hdr, dat;
  logic chk_ok, full;
  always_comb begin
    if (short_q) begin
      hdr    = rx_sr[2*BYTE_W-1 -: BYTE_W];
      dat    = rx_sr[BYTE_W-1:0];
      chk_ok = 1'b1;
      full   = (bit_cnt == LEN_SHORT);
    end else begin
      hdr    = rx_sr[FRAME_W-1 -: BYTE_W];
      dat    = rx_sr[2*BYTE_W-1 -: BYTE_W];
      chk_ok = (chk5(rx_sr[FRAME_W-1:CHK_W]) == rx_sr[CHK_W-1:0]);
      full   = (bit_cnt == LEN_LONG);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cs_d     <= 1'b1;
      in_frame <= 1'b0;
      short_q  <= 1'b0;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      lat_in   <= '0;
      lat_wb   <= '0;
      rsp1     <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
      if (cs_fall) begin
        in_frame <= 1'b1;
        short_q  <= mode_i;
        bit_cnt  <= '0;
        rx_sr    <= '0;
        tx_sr    <= in_state_i;
        lat_in   <= in_state_i;
        lat_wb   <= wb_state_i;
      end else if (cs_rise) begin
        in_frame <= 1'b0;
      end else if (in_frame && sclk_rise) begin
        rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
      end else if (in_frame && sclk_fall) begin
        if (bit_cnt == B1_AT) begin
          tx_sr <= byte1;
          rsp1  <= byte1;
        end else if (bit_cnt == B2_AT && !short_q) begin
          tx_sr <= {{(BYTE_W-CHK_W){1'b0}}, rsp_chk};
        end else begin
          tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_o <= 1'b0;
      chk_err_o   <= 1'b0;
      cmd_o       <= '0;
    end else begin
      cmd_valid_o <= in_frame & cs_rise & full & chk_ok & hdr[BYTE_W-1];
      chk_err_o   <= in_frame & cs_rise & full & ~short_q & ~chk_ok;
      cmd_o.addr  <= hdr[ADDR_W-1:0];
      cmd_o.data  <= dat;
    end
  end

endmodule

// File: rtl/spi_frame_regfile.sv
module spi_frame_regfile
  import spi_frame_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  wr_cmd_t           cmd_i,
  input  logic              chk_err_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [BYTE_W-1:0] in_state_i,
  input  logic [BYTE_W-1:0] wb_state_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] cfg_o,
  output logic [BYTE_W-1:0] chen_o,
  output logic [BYTE_W-1:0] flt1_o,
  output logic [BYTE_W-1:0] flt1en_o,
  output logic [BYTE_W-1:0] flt2_o,
  output logic [BYTE_W-1:0] flt2en_o,
  output logic              fault_o
);

  localparam int F2_W = 6;

  logic [BYTE_W-1:0] cfg_r, chen_r, f1en_r;
  logic [4:0]        f1_lo;
  logic              f1_por, f1_chk;
  logic [F2_W-1:0]   f2_r, f2en_r;

  assign cfg_o    = cfg_r;
  assign chen_o   = chen_r;
  assign flt1en_o = f1en_r;
  assign flt2_o   = {{(BYTE_W-F2_W){1'b0}}, f2_r};
  assign flt2en_o = {{(BYTE_W-F2_W){1'b0}}, f2en_r};
  assign flt1_o   = {f1_chk, f1_por, |f2_r, f1_lo};
  assign fault_o  = |(flt1_o & f1en_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r  <= '0;
      chen_r <= '1;
      f1en_r <= '0;
      f1_lo  <= '0;
      f1_por <= 1'b1;
      f1_chk <= 1'b0;
      f2_r   <= '0;
      f2en_r <= '0;
    end else if (chk_err_i) begin
      f1_chk <= 1'b1;
    end else if (cmd_valid_i) begin
      unique case (cmd_i.addr)
        A_CONFIG: cfg_r  <= cmd_i.data;
        A_CHEN:   chen_r <= cmd_i.data;
        A_FLT1EN: f1en_r <= cmd_i.data;
        A_FLT2:   f2_r   <= cmd_i.data[F2_W-1:0];
        A_FLT2EN: f2en_r <= cmd_i.data[F2_W-1:0];
        A_FLT1: begin
          f1_chk <= f1_chk & cmd_i.data[7];
          f1_por <= f1_por & cmd_i.data[6];
          f1_lo  <= cmd_i.data[4:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_WIRE:   rd_data_o = wb_state_i;
      A_INPUT:  rd_data_o = in_state_i;
      A_FLT1:   rd_data_o = flt1_o;
      A_CONFIG: rd_data_o = cfg_r;
      A_CHEN:   rd_data_o = chen_r;
      A_FLT2:   rd_data_o = flt2_o;
      A_FLT2EN: rd_data_o = flt2en_o;
      A_FLT1EN: rd_data_o = f1en_r;
      default:  rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/spi_frame_regs.sv
module spi_frame_regs
  import spi_frame_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              frame_mode,
  input  logic [BYTE_W-1:0] in_state,
  input  logic [BYTE_W-1:0] wb_state,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] chan_en_q,
  output logic [BYTE_W-1:0] fault1_q,
  output logic [BYTE_W-1:0] fault1_en_q,
  output logic [BYTE_W-1:0] fault2_q,
  output logic [BYTE_W-1:0] fault2_en_q,
  output logic              fault_o
);

  logic [2:0] pins_s;

  spi_frame_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sclk, cs_n, mosi}),
    .q_o   (pins_s)
  );

  logic [ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_data;
  logic              cmd_valid, chk_err;
  wr_cmd_t           cmd;

  spi_frame_engine u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_s      (pins_s[2]),
    .cs_n_s      (pins_s[1]),
    .mosi_s      (pins_s[0]),
    .mode_i      (frame_mode),
    .in_state_i  (in_state),
    .wb_state_i  (wb_state),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .miso_o      (miso),
    .cmd_valid_o (cmd_valid),
    .cmd_o       (cmd),
    .chk_err_o   (chk_err)
  );

  spi_frame_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .chk_err_i   (chk_err),
    .rd_addr_i   (rd_addr),
    .in_state_i  (in_state),
    .wb_state_i  (wb_state),
    .rd_data_o   (rd_data),
    .cfg_o       (cfg_q),
    .chen_o      (chan_en_q),
    .flt1_o      (fault1_q),
    .flt1en_o    (fault1_en_q),
    .flt2_o      (fault2_q),
    .flt2en_o    (fault2_en_q),
    .fault_o     (fault_o)
  );

endmodule

// File: rtl/spi_frame_regs_chk.sv
module spi_frame_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic [7:0] cfg_q,
  input logic [7:0] chan_en_q,
  input logic [7:0] fault1_q,
  input logic [7:0] fault1_en_q,
  input logic [7:0] fault2_q,
  input logic [7:0] fault2_en_q,
  input logic       fault_o
);

  // idle output once chip-select has been high for the synchronizer latency
  assert_idle_miso_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

  // registers only move shortly after a frame ends (default sync depth)
  assert_no_write_outside_frame_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4) && $past(cs_n, 5))
    |-> ($stable(cfg_q) && $stable(chan_en_q) && $stable(fault1_en_q) &&
         $stable(fault2_q) && $stable(fault2_en_q)));

  assert_por_never_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(fault1_q[6]));

  assert_fault2_summary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault2_q != 8'h00) |-> fault1_q[5]);

  assert_fault_pin_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault1_q & fault1_en_q) != 8'h00) |-> fault_o);

  assert_fault_pin_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> ((fault1_q & fault1_en_q) != 8'h00));

  assert_chk_flag_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault1_q[7]) |-> cs_n);

endmodule

bind spi_frame_regs spi_frame_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .miso        (miso),
  .cfg_q       (cfg_q),
  .chan_en_q   (chan_en_q),
  .fault1_q    (fault1_q),
  .fault1_en_q (fault1_en_q),
  .fault2_q    (fault2_q),
  .fault2_en_q (fault2_en_q),
  .fault_o     (fault_o)
);

// File: tb/spi_frame_regs_bench.sv
`timescale 1ns/1ps
module spi_frame_regs_bench;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic frame_mode = 1'b0;
  logic [7:0] in_state = 8'h3C;
  logic [7:0] wb_state = 8'h81;
  logic miso, fault_o;
  logic [7:0] cfg_q, chan_en_q, fault1_q, fault1_en_q, fault2_q, fault2_en_q;

  always #4 clk = ~clk;

  spi_frame_regs u_spi_frame_regs (
    .clk (clk), .rst_n (rst_n), .sclk (sclk), .cs_n (cs_n), .mosi (mosi),
    .miso (miso), .frame_mode (frame_mode), .in_state (in_state), .wb_state (wb_state),
    .cfg_q (cfg_q), .chan_en_q (chan_en_q), .fault1_q (fault1_q),
    .fault1_en_q (fault1_en_q), .fault2_q (fault2_q), .fault2_en_q (fault2_en_q),
    .fault_o (fault_o)
  );

  int n_checks = 0;
  int n_fail = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // register model
  logic [7:0] m_cfg = 8'h00, m_chen = 8'hFF, m_f1en = 8'h00;
  logic [4:0] m_f1lo = 5'h00;
  logic       m_por = 1'b1, m_chk = 1'b0;
  logic [5:0] m_f2 = 6'h00, m_f2en = 6'h00;

  logic       late_en = 1'b0;
  logic [7:0] late_val = 8'h00;

  function automatic logic [7:0] m_f1();
    return {m_chk, m_por, |m_f2, m_f1lo};
  endfunction

  function automatic logic [7:0] m_read(input logic [6:0] a);
    case (a)
      7'h00: return wb_state;
      7'h02: return in_state;
      7'h04: return m_f1();
      7'h18: return m_cfg;
      7'h1A: return m_chen;
      7'h1C: return {2'b00, m_f2};
      7'h1E: return {2'b00, m_f2en};
      7'h24: return m_f1en;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input logic [6:0] a, input logic [7:0] d);
    case (a)
      7'h18: m_cfg = d;
      7'h1A: m_chen = d;
      7'h24: m_f1en = d;
      7'h1C: m_f2 = d[5:0];
      7'h1E: m_f2en = d[5:0];
      7'h04: begin m_chk = m_chk & d[7]; m_por = m_por & d[6]; m_f1lo = d[4:0]; end
      default: ;
    endcase
  endtask

  // long division of {19 bits, 00111} by 110101
  function automatic logic [4:0] ref_chk(input logic [18:0] d);
    logic [23:0] w;
    w = {d, 5'b00111};
    for (int i = 23; i >= 5; i--)
      if (w[i]) w[i -: 6] = w[i -: 6] ^ 6'b110101;
    return w[4:0];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic expect_rsp(input logic short_f, input logic [7:0] e0, input logic [7:0] e1,
                            input string tag);
    push(e0, {tag, " R2 byte0"});
    push(e1, {tag, " byte1"});
    if (!short_f) push({3'b000, ref_chk({e0, e1, 3'b000})}, {tag, " R6 check byte"});
  endtask

  task automatic send(input int nbits, input logic [31:0] w);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[31-i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      if (late_en && i == 2) in_state = late_val;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  function automatic logic [31:0] build(input logic short_f, input logic [7:0] b0,
                                        input logic [7:0] b1, input logic bad);
    logic [4:0] c;
    c = ref_chk({b0, b1, 3'b000}) ^ {4'b0000, bad};
    if (short_f) return {b0, b1, 16'h0000};
    return {b0, b1, 3'b000, c, 8'h00};
  endfunction

  task automatic wr(input logic short_f, input logic [6:0] a, input logic [7:0] d, input string tag);
    frame_mode = short_f;
    expect_rsp(short_f, in_state, wb_state, {tag, " R3 write rsp"});
    send(short_f ? 16 : 24, build(short_f, {1'b1, a}, d, 1'b0));
    m_write(a, d);
  endtask

  task automatic rd(input logic short_f, input logic [6:0] a, input logic [7:0] junk, input string tag);
    frame_mode = short_f;
    expect_rsp(short_f, in_state, m_read(a), {tag, " R4 read rsp"});
    send(short_f ? 16 : 24, build(short_f, {1'b0, a}, junk, 1'b0));
  endtask

  task automatic check_ports(input string tag);
    check({tag, " register ports"},
          {16'h0, cfg_q, chan_en_q, fault1_q, fault1_en_q, fault2_q, fault2_en_q},
          {16'h0, m_cfg, m_chen, m_f1(), m_f1en, {2'b00, m_f2}, {2'b00, m_f2en}});
    check({tag, " R11 fault_o"}, {63'h0, fault_o}, {63'h0, |(m_f1() & m_f1en)});
  endtask

  // monitor: collects miso on sclk rises, compares completed bytes
  initial begin
    logic [7:0] sr;
    int nb;
    sr = 8'h00;
    nb = 0;
    forever begin
      @(posedge sclk or negedge cs_n);
      if (!sclk) begin
        nb = 0;
      end else if (!cs_n) begin
        sr = {sr[6:0], miso};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) begin
            check("R13 unexpected response byte", {56'h0, sr}, 64'hFFFF);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {56'h0, sr}, {56'h0, e});
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    check_ports("R12 R9 reset");
    check("R13 idle miso", {63'h0, miso}, 64'h0);

    // long frames: write and read back
    wr(1'b0, 7'h18, 8'hA5, "R1 R5 cfg write long");
    check_ports("R1 cfg write long");
    rd(1'b0, 7'h18, 8'h5A, "R4 cfg read long junk byte");
    check_ports("R4 read changes nothing");

    // short frames
    wb_state = 8'h42;
    in_state = 8'hC3;
    wr(1'b1, 7'h1A, 8'h0F, "R5 chen write short");
    check_ports("R5 chen write short");
    rd(1'b1, 7'h1A, 8'hFF, "R5 chen read short");

    // live vectors, NOP and unmapped reads
    rd(1'b0, 7'h00, 8'h00, "R4 wire-break live");
    rd(1'b1, 7'h02, 8'h00, "R4 input live");
    rd(1'b0, 7'h26, 8'h00, "R4 nop reads zero");
    rd(1'b1, 7'h30, 8'h00, "R4 unmapped reads zero");

    // writes to read-only addresses
    wr(1'b0, 7'h02, 8'hEE, "R12 write input addr");
    wr(1'b1, 7'h00, 8'hEE, "R12 write wire addr");
    wr(1'b0, 7'h26, 8'hEE, "R12 write nop addr");
    check_ports("R12 read-only writes ignored");

    // bad check code
    frame_mode = 1'b0;
    expect_rsp(1'b0, in_state, wb_state, "R7 bad-check rsp");
    send(24, build(1'b0, {1'b1, 7'h18}, 8'h11, 1'b1));
    m_chk = 1'b1;
    check_ports("R7 bad check no write");
    rd(1'b0, 7'h04, 8'h00, "R7 fault1 shows check error");

    // power-on and check flags
    wr(1'b0, 7'h04, 8'hBF, "R9 clear por keep chk");
    check_ports("R9 por cleared");
    wr(1'b1, 7'h04, 8'h00, "R9 clear all");
    check_ports("R9 fault1 cleared");

    // fault pin
    wr(1'b0, 7'h24, 8'h01, "R11 enable bit0");
    check_ports("R11 enabled but inactive");
    wr(1'b0, 7'h04, 8'h01, "R11 set bit0");
    check_ports("R11 fault asserted");
    wr(1'b1, 7'h24, 8'h00, "R11 disable");
    check_ports("R11 fault released");

    // fault2 summary
    wr(1'b0, 7'h1C, 8'hFF, "R10 fault2 set");
    wr(1'b0, 7'h1E, 8'hC7, "R10 fault2 enable");
    check_ports("R10 fault2 summary");
    rd(1'b0, 7'h04, 8'h00, "R10 fault1 read summary");
    wr(1'b1, 7'h24, 8'h20, "R11 enable summary");
    check_ports("R11 fault from summary");
    wr(1'b1, 7'h1C, 8'h00, "R10 fault2 clear");
    check_ports("R10 summary clears");

    // aborted and overlong frames
    frame_mode = 1'b0;
    push(in_state, "R8 abort byte0");
    push(wb_state, "R8 abort byte1");
    send(20, build(1'b0, {1'b1, 7'h18}, 8'h33, 1'b0));
    check_ports("R8 short abort no write");
    frame_mode = 1'b1;
    push(in_state, "R8 overlong byte0");
    push(wb_state, "R8 overlong byte1");
    push(8'h00, "R13 trailing zeros");
    send(24, {8'h98, 8'h77, 8'h55, 8'h00});
    check_ports("R8 overlong no write");

    // input state captured at chip-select fall
    late_val = 8'h99;
    late_en = 1'b1;
    rd(1'b0, 7'h18, 8'h00, "R2 late input change");
    late_en = 1'b0;
    rd(1'b1, 7'h02, 8'h00, "R4 input live after change");

    check("R13 idle miso end", {63'h0, miso}, 64'h0);
    check("R2 all response bytes seen", {32'h0, exp_q.size()}, 64'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule